// File: doc/BRIEF.md
# Display Status and Interrupt Controller

This block keeps the sticky event state of a multi-channel display controller and turns it into one level-sensitive interrupt line. Seven frame-fetch channels, plus a set of controller-wide sources, report events to it as single-cycle strobes. Each event sets a bit in one of two status words. Channel 0 and the controller-wide events live in the main word. Channels 1 to 6 live in a secondary word, in four 8-bit lanes. Software clears bits by writing ones to them through a small register port.

Masks for the main word come in as input pins. The mask for the secondary word is a register inside the block. The interrupt output is the registered OR of every status bit whose mask bit is clear.

The block also records which frame caused the interrupt. Each channel presents the frame identifier it is working on. When a qualifying event arrives while the line is low, that channel's identifier is captured. When the line is already high, a second-interrupt flag is raised and the identifier already captured is left as it is.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Main status bits are set by strobes as follows: last-frame-done to bit 0, channel-0 start to bit 1, bus error to bit 2, bias count to bit 3, underrun channel 0 to bit 4, underrun channel 1 to bit 5, output underrun to bit 6, quick-disable to bit 7, channel-0 end to bit 8, channel-0 branch to bit 9, read status to bit 11, command to bit 12. A bus error also loads `ber_chan` into bits 30:28. The second-interrupt flag is bit 10. This word is read at address 0.
- R3: For channel c in 1..6, the secondary word (address 1) sets start at bit c-1, end at bit c+7 and branch at bit c+15. For c in 2..6, underrun sets bit c+23.
- R4: A write to address 0 clears each of bits 11:0 that is written as one. Bit 12 is unaffected. Writing one to bit 2 also zeroes bits 30:28.
- R5: A write to address 1 clears only those one-bits that also lie under 0x003E3F3F.
- R6: When a strobe and a write-one-clear hit the same bit in the same cycle, the bit ends up set.
- R7: `irq` is registered. One clock after a status or mask change, it equals the OR of the main bits whose `main_mask` bit is clear, together with the secondary bits whose mask-register bit is clear. Main bits 2, 3 and 10 never contribute. Bit 5 is gated by mask-register bit 24, not by `main_mask[5]`.
- R8: An unmasked start, end or branch event captures that channel's `frame_id` slice into the ID register (address 2) when `irq` is low. If several channels qualify in one cycle, the highest channel number wins. Masked events capture nothing.
- R9: A qualifying event that arrives while `irq` is high sets main bit 10 and leaves the ID register unchanged.
- R10: A bus error qualifies for the capture rule of R8 and R9 on channel `ber_chan`, whatever the masks.
- R11: A one-to-zero change of `ctl_en` between two clocks sets main bit 7.
- R12: A write to address 3 loads the mask register with `reg_wdata` AND 0x3F3F3F3F. A write to address 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_evt | input | 7 | Start-of-frame strobe per channel |
| eof_evt | input | 7 | End-of-frame strobe per channel |
| brn_evt | input | 7 | Branch-taken strobe per channel |
| und_evt | input | 7 | Input underrun strobe per channel |
| ber_evt | input | 1 | Bus error strobe |
| ber_chan | input | 3 | Channel of the bus error |
| ldd_evt | input | 1 | Last frame done strobe |
| abc_evt | input | 1 | Bias count strobe |
| ovr_evt | input | 1 | Output underrun strobe |
| rdst_evt | input | 1 | Read status strobe |
| cmd_evt | input | 1 | Command interrupt strobe |
| ctl_en | input | 1 | Controller enable level |
| main_mask | input | 13 | Mask bits aligned with main status bits, 1 masks |
| frame_id | input | 7*IDW | Current frame identifier of each channel, channel c at [c*IDW +: IDW] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the bits that are easy to get wrong:
- Main bit 12 and secondary bits 16, 24 and 25 must survive an all-ones clear. A design using a uniform clear mask would drop them.
- A bus error raised with every mask set must still capture the identifier. A design gating it by mask would leave the ID register at zero.
- Two channels firing together must leave the higher channel's identifier.
- An event arriving while the line is high must set the second-interrupt flag without touching the ID register.
- A strobe colliding with a clear of the same bit must stick.
- The line must stay low for bus error and bias count, and one cycle of latency after a mask change is checked exactly.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    localparam int NCH    = 7;
    localparam int CHW    = 3;
    localparam int REGW   = 32;
    localparam int MAIN_W = 13;

    localparam int B_LDD  = 0;
    localparam int B_SOF0 = 1;
    localparam int B_BER  = 2;
    localparam int B_ABC  = 3;
    localparam int B_UND0 = 4;
    localparam int B_UND1 = 5;
    localparam int B_OVR  = 6;
    localparam int B_QD   = 7;
    localparam int B_EOF0 = 8;
    localparam int B_BRN0 = 9;
    localparam int B_SINT = 10;
    localparam int B_RDST = 11;
    localparam int B_CMD  = 12;

    localparam int SEC_EOF_OFS = 7;
    localparam int SEC_BRN_OFS = 15;
    localparam int SEC_UND_OFS = 23;

    localparam logic [REGW-1:0] SEC_CLR_MASK  = 32'h003E_3F3F;
    localparam logic [REGW-1:0] SEC_KEEP_MASK = 32'h3F3F_3F3F;

    typedef enum logic [1:0] {
        ADDR_MAIN  = 2'd0,
        ADDR_SEC   = 2'd1,
        ADDR_ID    = 2'd2,
        ADDR_SMASK = 2'd3
    } dirq_addr_e;
endpackage

// File: rtl/dirq_evt_map.sv
module dirq_evt_map import dirq_pkg::*; #(
    parameter int IDW = 32
) (
    input  logic [NCH-1:0]     sof_evt,
    input  logic [NCH-1:0]     eof_evt,
    input  logic [NCH-1:0]     brn_evt,
    input  logic [NCH-1:0]     und_evt,
    input  logic               ber_evt,
    input  logic [CHW-1:0]     ber_chan,
    input  logic               ldd_evt,
    input  logic               abc_evt,
    input  logic               ovr_evt,
    input  logic               rdst_evt,
    input  logic               cmd_evt,
    input  logic [2:0]         ch0_mask,   // {branch, end, start} masks of channel 0
    input  logic [REGW-1:0]    sec_mask,
    input  logic [NCH*IDW-1:0] frame_id,
    output logic [MAIN_W-1:0]  main_set,
    output logic [REGW-1:0]    sec_set,
    output logic               cap_hit,
    output logic [IDW-1:0]     cap_id
);
    logic [NCH-1:0] cand;
    logic           unused_bits;

    assign unused_bits = ^{sec_mask[31:22], sec_mask[15:14], sec_mask[7:6]};

    // one capture lane per channel; channel 0 takes its masks from pins
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic ber_here;
        assign ber_here = ber_evt && (ber_chan == CHW'(c));
        if (c == 0) begin : g_main
            assign cand[c] = (sof_evt[c] & ~ch0_mask[0])
                           | (eof_evt[c] & ~ch0_mask[1])
                           | (brn_evt[c] & ~ch0_mask[2])
                           | ber_here;
        end else begin : g_sec
            assign cand[c] = (sof_evt[c] & ~sec_mask[c-1])
                           | (eof_evt[c] & ~sec_mask[c+SEC_EOF_OFS])
                           | (brn_evt[c] & ~sec_mask[c+SEC_BRN_OFS])
                           | ber_here;
        end
    end

    always_comb begin
        main_set         = '0;
        main_set[B_LDD]  = ldd_evt;
        main_set[B_SOF0] = sof_evt[0];
        main_set[B_BER]  = ber_evt;
        main_set[B_ABC]  = abc_evt;
        main_set[B_UND0] = und_evt[0];
        main_set[B_UND1] = und_evt[1];
        main_set[B_OVR]  = ovr_evt;
        main_set[B_EOF0] = eof_evt[0];
        main_set[B_BRN0] = brn_evt[0];
        main_set[B_RDST] = rdst_evt;
        main_set[B_CMD]  = cmd_evt;

        sec_set = '0;
        for (int c = 1; c < NCH; c++) begin
            sec_set[c-1]           = sof_evt[c];
            sec_set[c+SEC_EOF_OFS] = eof_evt[c];
            sec_set[c+SEC_BRN_OFS] = brn_evt[c];
            if (c >= 2) sec_set[c+SEC_UND_OFS] = und_evt[c];
        end

        // ascending scan: the highest qualifying channel is written last
        cap_id = '0;
        for (int c = 0; c < NCH; c++) begin
            if (cand[c]) cap_id = frame_id[c*IDW +: IDW];
        end
        cap_hit = |cand;
    end
endmodule

// File: rtl/dirq_level.sv
module dirq_level import dirq_pkg::*; (
    input  logic [MAIN_W-1:0] main_st,
    input  logic [MAIN_W-1:0] main_mask,
    input  logic [REGW-1:0]   sec_st,
    input  logic [REGW-1:0]   sec_mask,
    output logic              level
);
    logic [MAIN_W-1:0] main_en;

    always_comb begin
        main_en         = ~main_mask;
        main_en[B_BER]  = 1'b0;
        main_en[B_ABC]  = 1'b0;
        main_en[B_SINT] = 1'b0;
        main_en[B_UND1] = ~sec_mask[1+SEC_UND_OFS];
        level = (|(main_st & main_en)) | (|(sec_st & ~sec_mask));
    end
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl import dirq_pkg::*; #(
    parameter int IDW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     sof_evt,
    input  logic [NCH-1:0]     eof_evt,
    input  logic [NCH-1:0]     brn_evt,
    input  logic [NCH-1:0]     und_evt,
    input  logic               ber_evt,
    input  logic [CHW-1:0]     ber_chan,
    input  logic               ldd_evt,
    input  logic               abc_evt,
    input  logic               ovr_evt,
    input  logic               rdst_evt,
    input  logic               cmd_evt,
    input  logic               ctl_en,
    input  logic [MAIN_W-1:0]  main_mask,
    input  logic [NCH*IDW-1:0] frame_id,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REGW-1:0]    reg_wdata,
    output logic [REGW-1:0]    reg_rdata,
    output logic               irq
);
    typedef struct packed {
        logic [MAIN_W-1:0] main_st;
        logic [CHW-1:0]    ber_ch;
        logic [REGW-1:0]   sec_st;
        logic [IDW-1:0]    int_id;
        logic [REGW-1:0]   sec_mask;
        logic              en_prev;
        logic              irq;
    } st_t;

    st_t state_d, state_q;

    logic [MAIN_W-1:0] main_set;
    logic [REGW-1:0]   sec_set;
    logic              cap_hit;
    logic [IDW-1:0]    cap_id;
    logic              level;

    dirq_evt_map #(.IDW(IDW)) map_i (
        .sof_evt  (sof_evt),
        .eof_evt  (eof_evt),
        .brn_evt  (brn_evt),
        .und_evt  (und_evt),
        .ber_evt  (ber_evt),
        .ber_chan (ber_chan),
        .ldd_evt  (ldd_evt),
        .abc_evt  (abc_evt),
        .ovr_evt  (ovr_evt),
        .rdst_evt (rdst_evt),
        .cmd_evt  (cmd_evt),
        .ch0_mask ({main_mask[B_BRN0], main_mask[B_EOF0], main_mask[B_SOF0]}),
        .sec_mask (state_q.sec_mask),
        .frame_id (frame_id),
        .main_set (main_set),
        .sec_set  (sec_set),
        .cap_hit  (cap_hit),
        .cap_id   (cap_id)
    );

    dirq_level level_i (
        .main_st   (state_q.main_st),
        .main_mask (main_mask),
        .sec_st    (state_q.sec_st),
        .sec_mask  (state_q.sec_mask),
        .level     (level)
    );

    always_comb begin
        logic              wr_main, wr_sec, wr_smask;
        logic [MAIN_W-1:0] clr_main, set_main;
        logic [REGW-1:0]   clr_sec;

        state_d  = state_q;
        wr_main  = reg_wr && (reg_addr == ADDR_MAIN);
        wr_sec   = reg_wr && (reg_addr == ADDR_SEC);
        wr_smask = reg_wr && (reg_addr == ADDR_SMASK);

        clr_main = wr_main ? {1'b0, reg_wdata[B_RDST:0]} : '0;
        clr_sec  = wr_sec ? (reg_wdata & SEC_CLR_MASK) : '0;

        set_main = main_set;
        set_main[B_QD]   = main_set[B_QD] | (state_q.en_prev & ~ctl_en);
        set_main[B_SINT] = cap_hit & state_q.irq;

        state_d.main_st = (state_q.main_st & ~clr_main) | set_main;
        state_d.sec_st  = (state_q.sec_st & ~clr_sec) | sec_set;

        if (wr_main && reg_wdata[B_BER]) state_d.ber_ch = '0;
        if (ber_evt)                     state_d.ber_ch = ber_chan;

        if (cap_hit && !state_q.irq) state_d.int_id = cap_id;
        if (wr_smask) state_d.sec_mask = reg_wdata & SEC_KEEP_MASK;

        state_d.en_prev = ctl_en;
        state_d.irq     = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_MAIN:  reg_rdata = {1'b0, state_q.ber_ch, {(REGW-MAIN_W-4){1'b0}}, state_q.main_st};
            ADDR_SEC:   reg_rdata = state_q.sec_st;
            ADDR_ID:    reg_rdata = REGW'(state_q.int_id);
            default:    reg_rdata = state_q.sec_mask;
        endcase
    end

    assign irq = state_q.irq;
endmodule

// File: rtl/dirq_chk.sv
module dirq_chk import dirq_pkg::*; #(
    parameter int IDW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              ldd_evt,
    input logic              ber_evt,
    input logic [CHW-1:0]    ber_chan,
    input logic              irq,
    input logic              cap_hit,
    input logic              en_prev,
    input logic [MAIN_W-1:0] main_st,
    input logic [CHW-1:0]    ber_ch,
    input logic [REGW-1:0]   sec_st,
    input logic [IDW-1:0]    int_id
);
    assert_quiet_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_st == '0 && sec_st == '0) |=> !irq);

    assert_sint_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit && irq) |=> main_st[B_SINT]);

    assert_id_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> $stable(int_id));

    assert_quick_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_prev && !ctl_en) |=> main_st[B_QD]);

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ldd_evt |=> main_st[B_LDD]);

    assert_ber_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ber_evt |=> (ber_ch == $past(ber_chan)));
endmodule

bind disp_irq_ctrl dirq_chk #(.IDW(IDW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_en   (ctl_en),
    .ldd_evt  (ldd_evt),
    .ber_evt  (ber_evt),
    .ber_chan (ber_chan),
    .irq      (irq),
    .cap_hit  (cap_hit),
    .en_prev  (state_q.en_prev),
    .main_st  (state_q.main_st),
    .ber_ch   (state_q.ber_ch),
    .sec_st   (state_q.sec_st),
    .int_id   (state_q.int_id)
);

// File: tb/disp_irq_ctrl_tb_top.sv
module disp_irq_ctrl_tb_top;
    import dirq_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int IDW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] sof_evt, eof_evt, brn_evt, und_evt;
    logic ber_evt, ldd_evt, abc_evt, ovr_evt, rdst_evt, cmd_evt, ctl_en;
    logic [CHW-1:0] ber_chan;
    logic [MAIN_W-1:0] main_mask;
    logic [NCH*IDW-1:0] frame_id;
    logic reg_wr;
    logic [1:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_irq_ctrl #(.IDW(IDW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sof_evt(sof_evt), .eof_evt(eof_evt), .brn_evt(brn_evt), .und_evt(und_evt),
        .ber_evt(ber_evt), .ber_chan(ber_chan), .ldd_evt(ldd_evt), .abc_evt(abc_evt),
        .ovr_evt(ovr_evt), .rdst_evt(rdst_evt), .cmd_evt(cmd_evt), .ctl_en(ctl_en),
        .main_mask(main_mask), .frame_id(frame_id),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] fid(int c);
        return 32'h1000_0000 + 32'(c);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_events();
        sof_evt = '0; eof_evt = '0; brn_evt = '0; und_evt = '0;
        ber_evt = 0; ldd_evt = 0; abc_evt = 0; ovr_evt = 0; rdst_evt = 0; cmd_evt = 0;
        reg_wr = 0;
    endtask

    // one clock edge with the current stimulus, back at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_events();
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_events();
        ctl_en = 0; ber_chan = '0; main_mask = '1; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_main_map();
        logic [31:0] d;
        do_reset();
        wr(ADDR_SMASK, 32'hFFFF_FFFF);
        ldd_evt = 1; abc_evt = 1; ovr_evt = 1; rdst_evt = 1; cmd_evt = 1;
        und_evt[0] = 1; und_evt[1] = 1;
        step();
        rd(ADDR_MAIN, d);
        check("R2 main bit map", d, 32'h0000_1879);
        step();
        check("R7 all masked irq low", {31'b0, irq}, 32'h0);
        wr(ADDR_MAIN, 32'hFFFF_FFFF);
        rd(ADDR_MAIN, d);
        check("R4 bit 12 survives clear", d, 32'h0000_1000);
    endtask

    task automatic t_bus_error();
        logic [31:0] d;
        do_reset();
        wr(ADDR_SMASK, 32'hFFFF_FFFF);
        ber_evt = 1; ber_chan = 3'd5;
        step();
        rd(ADDR_MAIN, d);
        check("R2 bus error bit and channel", d, 32'h5000_0004);
        rd(ADDR_ID, d);
        check("R10 masked bus error captures id", d, fid(5));
        main_mask = '0;
        step(); step();
        check("R7 bus error never drives irq", {31'b0, irq}, 32'h0);
        wr(ADDR_MAIN, 32'h0000_0004);
        rd(ADDR_MAIN, d);
        check("R4 bus error clear zeroes channel", d, 32'h0);
    endtask

    task automatic t_sec_map();
        logic [31:0] d;
        do_reset();
        wr(ADDR_SMASK, 32'hFFFF_FFFF);
        sof_evt[3] = 1; eof_evt[6] = 1; brn_evt[1] = 1; brn_evt[4] = 1; und_evt[2] = 1;
        step();
        rd(ADDR_SEC, d);
        check("R3 secondary bit map", d, 32'h0209_2004);
        rd(ADDR_ID, d);
        check("R8 masked events do not capture", d, 32'h0);
        step();
        check("R7 masked secondary irq low", {31'b0, irq}, 32'h0);
        wr(ADDR_SEC, 32'hFFFF_FFFF);
        rd(ADDR_SEC, d);
        check("R5 restricted secondary clear", d, 32'h0201_0000);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        do_reset();
        main_mask = '0;
        sof_evt[2] = 1; eof_evt[4] = 1;
        step();
        rd(ADDR_SEC, d);
        check("R3 start ch2 and end ch4", d, 32'h0000_0802);
        rd(ADDR_ID, d);
        check("R8 highest channel captured", d, fid(4));
        check("R7 irq one clock late", {31'b0, irq}, 32'h0);
        step();
        check("R7 irq asserted", {31'b0, irq}, 32'h1);
        brn_evt[0] = 1;
        step();
        rd(ADDR_MAIN, d);
        check("R9 second interrupt flag", d, 32'h0000_0600);
        rd(ADDR_ID, d);
        check("R9 id kept while irq high", d, fid(4));
    endtask

    task automatic t_mask_timing();
        logic [31:0] d;
        do_reset();
        ldd_evt = 1;
        step();
        step();
        check("R7 masked ldd irq low", {31'b0, irq}, 32'h0);
        rd(ADDR_ID, d);
        check("R8 ldd does not capture", d, 32'h0);
        main_mask[B_LDD] = 0;
        step();
        check("R7 unmask raises irq", {31'b0, irq}, 32'h1);
        main_mask = '1;
        step();
        check("R7 remask drops irq", {31'b0, irq}, 32'h0);

        do_reset();
        main_mask = '0;
        wr(ADDR_SMASK, 32'h0100_0000);
        und_evt[1] = 1;
        step(); step();
        check("R7 ch1 underrun gated by bit 24", {31'b0, irq}, 32'h0);
        wr(ADDR_SMASK, 32'h0);
        check("R7 mask write one clock late", {31'b0, irq}, 32'h0);
        step();
        check("R7 ch1 underrun unmasked", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        do_reset();
        ldd_evt = 1;
        reg_wr = 1; reg_addr = ADDR_MAIN; reg_wdata = 32'h0000_0001;
        step();
        rd(ADDR_MAIN, d);
        check("R6 set beats clear", d, 32'h0000_0001);
    endtask

    task automatic t_quick_disable();
        logic [31:0] d;
        do_reset();
        ctl_en = 1;
        step();
        rd(ADDR_MAIN, d);
        check("R11 enable rise no flag", d, 32'h0);
        ctl_en = 0;
        step();
        rd(ADDR_MAIN, d);
        check("R11 enable fall sets flag", d, 32'h0000_0080);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(ADDR_SMASK, 32'hFFFF_FFFF);
        rd(ADDR_SMASK, d);
        check("R12 mask register keep bits", d, 32'h3F3F_3F3F);
        wr(ADDR_ID, 32'hDEAD_BEEF);
        rd(ADDR_ID, d);
        check("R12 id register write ignored", d, 32'h0);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) frame_id[c*IDW +: IDW] = fid(c);
        rst_n = 0;
        clear_events();
        ctl_en = 0; ber_chan = '0; main_mask = '1;
        reg_addr = '0; reg_wdata = '0;
        t_reset();
        t_main_map();
        t_bus_error();
        t_sec_map();
        t_capture();
        t_mask_timing();
        t_set_wins();
        t_quick_disable();
        t_regs();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule